// File: doc/BRIEF.md
# Virtual Scan-Chain Hub

This block lets one physical JTAG test access port serve several internal debug endpoints. It runs from the test clock and follows the sixteen-state TAP controller sequence itself, driven only by the TMS level at each rising clock edge. It also receives two decoded flags from the physical instruction register. One flag marks the instruction used for virtual-instruction access. The other marks the instruction used for virtual-data access.

A data scan taken while the instruction flag is set loads a virtual instruction word. That word holds an endpoint address and a private instruction for that endpoint. A data scan taken while the data flag is set goes to the addressed endpoint. Only that endpoint receives the incoming test data and the capture, shift and update strobes, and its test data output is returned on `tdo`. Address 0 names the hub itself. Addresses above the endpoint count name nothing. Each endpoint keeps its instruction on a parallel output and gets a one-cycle notice whenever that instruction takes a new value.

Top module: `vscan_hub`

## Requirements
- R1: The internal state tracker follows the standard TAP transitions. It enters Test-Logic-Reset on reset. Endpoint data strobes appear only in the data-column Capture, Shift and Update states, never on the instruction-register path. Pause-DR and Exit2-DR followed by a return to Shift-DR resume shifting.
- R2: While `ir_user1` is high, a data scan shifts `tdi` into a word of INSTR_W+ADDR_W bits, least significant bit first. On the Update-DR edge the word is taken in. Its high ADDR_W bits become the current address. For an address k in 1..N_NODES, its low INSTR_W bits become endpoint k's instruction, found at `node_instr[(k-1)*INSTR_W +: INSTR_W]`.
- R3: On Capture-DR while `ir_user1` is high, the shift word loads {current address, instruction of that address}. The instruction part is zero when the address names no endpoint. The word then appears on `tdo` least significant bit first during Shift-DR.
- R4: While `ir_user0` is high and `ir_user1` is low, during Shift-DR only the addressed endpoint's `node_shift` bit is high and only its `node_tdi` bit follows `tdi`. No bit is set when the address is 0 or above N_NODES.
- R5: `tdo` equals the addressed endpoint's `node_tdo` bit under `ir_user0`. It is 0 when the address names no endpoint, and 0 when neither instruction flag is high. `ir_user1` takes priority when both are high.
- R6: Under `ir_user0`, the addressed endpoint's `node_cap` and `node_upd` bits are high for exactly one cycle per scan, in Capture-DR and Update-DR respectively.
- R7: `node_upd_ir[k-1]` pulses high for exactly one cycle, the cycle after the Update-DR edge, only when endpoint k's instruction changes value.
- R8: Every clock edge spent in Test-Logic-Reset clears the current address and all endpoint instructions to zero.
- R9: A virtual instruction write whose address is 0 or above N_NODES changes no endpoint instruction and raises no `node_upd_ir` bit.
- R10: Driving `trst_n` low clears the address and all instructions at once, without waiting for a clock edge. Its release takes effect through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| ir_user0 | input | 1 | Physical IR holds the virtual-data instruction |
| ir_user1 | input | 1 | Physical IR holds the virtual-instruction instruction |
| tdo | output | 1 | Test data out to the physical chain |
| node_tdo | input | N_NODES | Test data out from each endpoint |
| node_tdi | output | N_NODES | Test data routed to the addressed endpoint |
| node_cap | output | N_NODES | Virtual Capture-DR strobe per endpoint |
| node_shift | output | N_NODES | Virtual Shift-DR enable per endpoint |
| node_upd | output | N_NODES | Virtual Update-DR strobe per endpoint |
| node_upd_ir | output | N_NODES | Virtual Update-IR pulse per endpoint |
| node_instr | output | N_NODES*INSTR_W | Latched instruction of every endpoint |

## Verification
If the state tracker drifts from the physical controller, the strobes arrive in the wrong scan cycles. That shows up as wrong strobe counts within the same scan, or as strobes during an instruction-register walk. A wrong address or instruction latch shows up on `node_instr` one cycle after Update-DR. It also shows up in the readback word of the very next instruction scan, bit by bit on `tdo`. A bad select shows at once during Shift-DR as the wrong `node_shift` bit or a `tdo` that does not follow the addressed endpoint.

// File: rtl/vjh_pkg.sv
package vjh_pkg;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SELDR, ST_CAPDR, ST_SHDR, ST_EX1DR, ST_PDR, ST_EX2DR, ST_UPDR,
    ST_SELIR, ST_CAPIR, ST_SHIR, ST_EX1IR, ST_PIR, ST_EX2IR, ST_UPIR
  } tap_state_e;

  function automatic tap_state_e tap_next(tap_state_e s, logic m);
    case (s)
      ST_TLR:   return m ? ST_TLR   : ST_RTI;
      ST_RTI:   return m ? ST_SELDR : ST_RTI;
      ST_SELDR: return m ? ST_SELIR : ST_CAPDR;
      ST_CAPDR: return m ? ST_EX1DR : ST_SHDR;
      ST_SHDR:  return m ? ST_EX1DR : ST_SHDR;
      ST_EX1DR: return m ? ST_UPDR  : ST_PDR;
      ST_PDR:   return m ? ST_EX2DR : ST_PDR;
      ST_EX2DR: return m ? ST_UPDR  : ST_SHDR;
      ST_UPDR:  return m ? ST_SELDR : ST_RTI;
      ST_SELIR: return m ? ST_TLR   : ST_CAPIR;
      ST_CAPIR: return m ? ST_EX1IR : ST_SHIR;
      ST_SHIR:  return m ? ST_EX1IR : ST_SHIR;
      ST_EX1IR: return m ? ST_UPIR  : ST_PIR;
      ST_PIR:   return m ? ST_EX2IR : ST_PIR;
      ST_EX2IR: return m ? ST_UPIR  : ST_SHIR;
      ST_UPIR:  return m ? ST_SELDR : ST_RTI;
      default:  return ST_TLR;
    endcase
  endfunction

endpackage

// File: rtl/vjh_tap_track.sv
module vjh_tap_track
  import vjh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state_q
);

  tap_state_e state_d;

  always_comb begin
    state_d = tap_next(state_q, tms);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_TLR;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/vjh_vir.sv
module vjh_vir #(
  parameter int N_NODES = 3,
  parameter int INSTR_W = 4,
  parameter int ADDR_W  = 8,
  localparam int VIR_W  = INSTR_W + ADDR_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tlr,
  input  logic                       cap_en,
  input  logic                       shift_en,
  input  logic                       upd_en,
  input  logic                       tdi,
  output logic                       sr_out,
  output logic [ADDR_W-1:0]          addr_q,
  output logic [N_NODES*INSTR_W-1:0] instr_flat,
  output logic [N_NODES-1:0]         upd_ir_q
);

  logic [VIR_W-1:0]   sr_q, sr_d;
  logic [INSTR_W-1:0] cur_instr;
  logic [ADDR_W-1:0]  new_addr;
  logic [INSTR_W-1:0] new_instr;

  assign new_addr  = sr_q[VIR_W-1:INSTR_W];
  assign new_instr = sr_q[INSTR_W-1:0];
  assign sr_out    = sr_q[0];

  always_comb begin
    cur_instr = '0;
    for (int i = 0; i < N_NODES; i++) begin
      if (addr_q == ADDR_W'(i + 1)) cur_instr = instr_flat[i*INSTR_W +: INSTR_W];
    end
  end

  always_comb begin
    sr_d = sr_q;
    if (cap_en)        sr_d = {addr_q, cur_instr};
    else if (shift_en) sr_d = {tdi, sr_q[VIR_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  sr_q <= '0;
    else if (cap_en || shift_en) sr_q <= sr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (tlr)    addr_q <= '0;
    else if (upd_en) addr_q <= new_addr;
  end

  for (genvar k = 0; k < N_NODES; k++) begin : g_node_ir
    logic [INSTR_W-1:0] ins_q;
    logic               hit;
    assign hit = upd_en && (new_addr == ADDR_W'(k + 1));
    assign instr_flat[k*INSTR_W +: INSTR_W] = ins_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ins_q <= '0;
      else if (tlr) ins_q <= '0;
      else if (hit) ins_q <= new_instr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   upd_ir_q[k] <= 1'b0;
      else if (tlr) upd_ir_q[k] <= 1'b0;
      else          upd_ir_q[k] <= hit && (new_instr != ins_q);
    end
  end

endmodule

// File: rtl/vscan_hub.sv
module vscan_hub
  import vjh_pkg::*;
#(
  parameter int N_NODES = 3,
  parameter int INSTR_W = 4,
  parameter int ADDR_W  = 8
) (
  input  logic                       tck,
  input  logic                       trst_n,
  input  logic                       tms,
  input  logic                       tdi,
  input  logic                       ir_user0,
  input  logic                       ir_user1,
  output logic                       tdo,
  input  logic [N_NODES-1:0]         node_tdo,
  output logic [N_NODES-1:0]         node_tdi,
  output logic [N_NODES-1:0]         node_cap,
  output logic [N_NODES-1:0]         node_shift,
  output logic [N_NODES-1:0]         node_upd,
  output logic [N_NODES-1:0]         node_upd_ir,
  output logic [N_NODES*INSTR_W-1:0] node_instr
);

  logic [1:0]        rst_sync_q;
  logic              rst_n;
  tap_state_e        state_q;
  logic              in_cap, in_shift, in_upd, in_tlr;
  logic              sel_u1, sel_u0;
  logic              vir_tdo;
  logic [ADDR_W-1:0] addr_q;
  logic [N_NODES-1:0] hit;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  vjh_tap_track u_track (
    .clk     (tck),
    .rst_n   (rst_n),
    .tms     (tms),
    .state_q (state_q)
  );

  assign in_cap   = (state_q == ST_CAPDR);
  assign in_shift = (state_q == ST_SHDR);
  assign in_upd   = (state_q == ST_UPDR);
  assign in_tlr   = (state_q == ST_TLR);
  assign sel_u1   = ir_user1;
  assign sel_u0   = ir_user0 && !ir_user1;

  vjh_vir #(
    .N_NODES (N_NODES),
    .INSTR_W (INSTR_W),
    .ADDR_W  (ADDR_W)
  ) u_vir (
    .clk        (tck),
    .rst_n      (trst_n && rst_n),
    .tlr        (in_tlr),
    .cap_en     (sel_u1 && in_cap),
    .shift_en   (sel_u1 && in_shift),
    .upd_en     (sel_u1 && in_upd),
    .tdi        (tdi),
    .sr_out     (vir_tdo),
    .addr_q     (addr_q),
    .instr_flat (node_instr),
    .upd_ir_q   (node_upd_ir)
  );

  for (genvar k = 0; k < N_NODES; k++) begin : g_route
    assign hit[k]        = sel_u0 && (addr_q == ADDR_W'(k + 1));
    assign node_cap[k]   = hit[k] && in_cap;
    assign node_shift[k] = hit[k] && in_shift;
    assign node_upd[k]   = hit[k] && in_upd;
    assign node_tdi[k]   = hit[k] && tdi;
  end

  always_comb begin
    if (sel_u1)      tdo = vir_tdo;
    else if (sel_u0) tdo = |(node_tdo & hit);
    else             tdo = 1'b0;
  end

endmodule

// File: rtl/vjh_checker.sv
module vjh_checker
  import vjh_pkg::*;
#(
  parameter int N_NODES = 3,
  parameter int INSTR_W = 4
) (
  input logic                       tck,
  input logic                       trst_n,
  input logic                       ir_user0,
  input logic                       ir_user1,
  input logic                       tdo,
  input logic [N_NODES-1:0]         node_cap,
  input logic [N_NODES-1:0]         node_shift,
  input logic [N_NODES-1:0]         node_upd,
  input logic [N_NODES-1:0]         node_upd_ir,
  input logic [N_NODES*INSTR_W-1:0] node_instr,
  input logic [3:0]                 tap_state
);

  a_r4_shift_onehot: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0(node_shift));

  a_r4_shift_needs_user0: assert property (@(posedge tck) disable iff (!trst_n)
    (|node_shift) |-> (ir_user0 && !ir_user1));

  a_r5_tdo_idle: assert property (@(posedge tck) disable iff (!trst_n)
    (!ir_user0 && !ir_user1) |-> !tdo);

  a_r6_cap_single: assert property (@(posedge tck) disable iff (!trst_n)
    (|node_cap) |=> !(|node_cap));

  a_r6_upd_single: assert property (@(posedge tck) disable iff (!trst_n)
    (|node_upd) |=> !(|node_upd));

  a_r7_updir_on_change: assert property (@(posedge tck) disable iff (!trst_n)
    (|node_upd_ir) |-> (node_instr != $past(node_instr)));

  a_r8_tlr_clears: assert property (@(posedge tck) disable iff (!trst_n)
    (tap_state == 4'(ST_TLR)) |=> (node_instr == '0));

endmodule

bind vscan_hub vjh_checker #(
  .N_NODES (N_NODES),
  .INSTR_W (INSTR_W)
) u_chk (
  .tck         (tck),
  .trst_n      (trst_n),
  .ir_user0    (ir_user0),
  .ir_user1    (ir_user1),
  .tdo         (tdo),
  .node_cap    (node_cap),
  .node_shift  (node_shift),
  .node_upd    (node_upd),
  .node_upd_ir (node_upd_ir),
  .node_instr  (node_instr),
  .tap_state   (state_q)
);

// File: tb/vscan_hub_tb.sv
module vscan_hub_tb;

  localparam int N  = 3;
  localparam int IW = 4;
  localparam int AW = 8;
  localparam int VW = IW + AW;
  localparam int NV = 7;

  localparam logic [VW-1:0] VEC [NV] = '{
    {8'd1, 4'hA}, {8'd2, 4'h5}, {8'd3, 4'hF}, {8'd2, 4'h5},
    {8'd0, 4'h7}, {8'd9, 4'h3}, {8'd1, 4'h3}
  };

  logic tck, trst_n, tms, tdi, ir_user0, ir_user1, tdo;
  logic [N-1:0]    node_tdo, node_tdi, node_cap, node_shift, node_upd, node_upd_ir;
  logic [N*IW-1:0] node_instr;

  int n_chk, n_bad;
  bit done;
  int cnt_cap [N];
  int cnt_sh  [N];
  int cnt_upd [N];
  int cnt_tdi [N];
  logic [N-1:0] updir_a, updir_b;
  logic [15:0]  dout;

  logic [AW-1:0] m_addr;
  logic [IW-1:0] m_ins [N];

  vscan_hub #(.N_NODES(N), .INSTR_W(IW), .ADDR_W(AW)) u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .ir_user0(ir_user0), .ir_user1(ir_user1), .tdo(tdo),
    .node_tdo(node_tdo), .node_tdi(node_tdi), .node_cap(node_cap),
    .node_shift(node_shift), .node_upd(node_upd),
    .node_upd_ir(node_upd_ir), .node_instr(node_instr)
  );

  initial tck = 1'b0;
  always #5 tck = ~tck;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr_counts();
    for (int k = 0; k < N; k++) begin
      cnt_cap[k] = 0; cnt_sh[k] = 0; cnt_upd[k] = 0; cnt_tdi[k] = 0;
    end
  endtask

  // drive at falling edge, then sample the state held since the last rising edge
  task automatic step(input logic m, input logic d);
    @(negedge tck);
    tms = m;
    tdi = d;
    #1;
    for (int k = 0; k < N; k++) begin
      cnt_cap[k] += int'(node_cap[k]);
      cnt_sh[k]  += int'(node_shift[k]);
      cnt_upd[k] += int'(node_upd[k]);
      cnt_tdi[k] += int'(node_tdi[k]);
    end
  endtask

  // full DR scan starting and ending in Run-Test/Idle
  task automatic dr_scan(input logic [15:0] din, input int len);
    clr_counts();
    dout = '0;
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    for (int b = 0; b < len; b++) begin
      step(b == len - 1, din[b]);
      dout[b] = tdo;
    end
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    updir_a = node_upd_ir;
    step(1'b0, 1'b0);
    updir_b = node_upd_ir;
  endtask

  function automatic logic [IW-1:0] m_rd(input logic [AW-1:0] a);
    if (a >= 1 && a <= N) return m_ins[a-1];
    return '0;
  endfunction

  function automatic logic [N*IW-1:0] m_flat();
    logic [N*IW-1:0] f;
    for (int k = 0; k < N; k++) f[k*IW +: IW] = m_ins[k];
    return f;
  endfunction

  initial begin
    repeat (100000) @(posedge tck);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0;
    ir_user0 = 1'b0; ir_user1 = 1'b0; node_tdo = '0;
    m_addr = '0;
    for (int k = 0; k < N; k++) m_ins[k] = '0;
    clr_counts();
    repeat (3) @(posedge tck);
    #2;
    // R10: reset state at the ports
    check(node_instr == '0, "R10 reset instr", 32'(node_instr), 0);
    check(tdo == 1'b0 && node_cap == '0 && node_shift == '0 && node_upd == '0 && node_upd_ir == '0,
          "R10 reset strobes", {tdo, node_cap, node_shift, node_upd, node_upd_ir}, 0);
    @(negedge tck);
    trst_n = 1'b1;
    repeat (3) step(1'b1, 1'b0);
    step(1'b0, 1'b0);

    // table walk: virtual IR write, readback, then a virtual DR scan
    for (int v = 0; v < NV; v++) begin
      logic [AW-1:0] a;
      logic [IW-1:0] ins;
      logic [N-1:0]  exp_ir;
      logic [VW-1:0] exp_rb;
      bit            inr;
      a   = VEC[v][VW-1:IW];
      ins = VEC[v][IW-1:0];
      inr = (a >= 1 && a <= N);
      exp_rb = {m_addr, m_rd(m_addr)};
      exp_ir = '0;
      if (inr && m_ins[a-1] != ins) exp_ir[a-1] = 1'b1;
      ir_user1 = 1'b1; ir_user0 = 1'b0;
      dr_scan(16'(VEC[v]), VW);
      check(dout[VW-1:0] == exp_rb, "R3 readback", 32'(dout[VW-1:0]), 32'(exp_rb));
      if (inr) m_ins[a-1] = ins;
      m_addr = a;
      check(node_instr == m_flat(), inr ? "R2 instr write" : "R9 ignored write",
            32'(node_instr), 32'(m_flat()));
      check(updir_a == exp_ir && updir_b == '0, "R7 update-ir pulse",
            {updir_a, updir_b}, {exp_ir, 3'b000});

      ir_user1 = 1'b0; ir_user0 = 1'b1;
      node_tdo = inr ? N'(1 << (a - 1)) : '1;
      dr_scan(16'hFFFF, 5);
      for (int k = 0; k < N; k++) begin
        bit sel;
        sel = inr && (a == AW'(k + 1));
        check(cnt_sh[k] == (sel ? 5 : 0) && cnt_tdi[k] == (sel ? 5 : 0), "R4 shift routing",
              {cnt_sh[k][15:0], cnt_tdi[k][15:0]}, sel ? 32'h00050005 : 0);
        check(cnt_cap[k] == (sel ? 1 : 0) && cnt_upd[k] == (sel ? 1 : 0), "R6 cap/upd strobes",
              {cnt_cap[k][15:0], cnt_upd[k][15:0]}, sel ? 32'h00010001 : 0);
      end
      check(dout[4:0] == (inr ? 5'h1F : 5'h00), "R5 tdo select",
            32'(dout[4:0]), inr ? 32'h1F : 0);
    end

    // R1: an IR-column walk gives no data strobes; pause/exit2 resumes shifting
    ir_user1 = 1'b1; ir_user0 = 1'b0;
    dr_scan(16'({8'd1, 4'h3}), VW);
    m_addr = 8'd1;
    ir_user1 = 1'b0; ir_user0 = 1'b1; node_tdo = 3'b001;
    clr_counts();
    step(1,0); step(1,0); step(0,0); step(0,0); step(1,0); step(0,0);
    step(1,0); step(0,0); step(1,0); step(1,0); step(0,0);
    check(cnt_sh[0] == 0 && cnt_cap[0] == 0 && cnt_upd[0] == 0, "R1 ir path quiet",
          32'(cnt_sh[0] + cnt_cap[0] + cnt_upd[0]), 0);
    clr_counts();
    step(1,0); step(0,0); step(0,0); step(0,0); step(1,0); step(0,0); step(0,0);
    step(1,0); step(0,0); step(0,0); step(1,0); step(1,0); step(0,0);
    check(cnt_sh[0] == 4 && cnt_cap[0] == 1 && cnt_upd[0] == 1, "R1 pause resume",
          {8'(cnt_sh[0]), 8'(cnt_cap[0]), 8'(cnt_upd[0])}, 32'h040101);

    // R5: neither instruction selected
    ir_user0 = 1'b0; ir_user1 = 1'b0; node_tdo = '1;
    dr_scan(16'hFFFF, 6);
    check(dout[5:0] == 6'h00 && cnt_sh[0] + cnt_sh[1] + cnt_sh[2] == 0, "R5 idle tdo",
          32'(dout[5:0]), 0);

    // R5: ir_user1 wins when both are high
    ir_user0 = 1'b1; ir_user1 = 1'b1;
    dr_scan(16'({8'd1, 4'h3}), VW);
    check(dout[VW-1:0] == {8'd1, 4'h3} && cnt_sh[0] == 0, "R5 user1 priority",
          32'(dout[VW-1:0]), 32'h013);

    // R8: Test-Logic-Reset clears address and instructions
    ir_user0 = 1'b0;
    check(node_instr != '0, "R8 precondition", 32'(node_instr), 1);
    repeat (5) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    check(node_instr == '0, "R8 tlr clear", 32'(node_instr), 0);
    dr_scan(16'({8'd2, 4'h9}), VW);
    check(dout[VW-1:0] == '0, "R8 address cleared", 32'(dout[VW-1:0]), 0);
    check(node_instr[IW +: IW] == 4'h9, "R2 write after tlr", 32'(node_instr), 32'h090);

    // R10: asynchronous reset clears without a clock edge
    @(negedge tck);
    #2;
    trst_n = 1'b0;
    #1;
    check(node_instr == '0, "R10 async clear", 32'(node_instr), 0);
    @(negedge tck);
    trst_n = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule